// File: doc/BRIEF.md
# PRBS9 Self-Synchronizing Bit Error Checker

This block sits after a demodulator and measures the bit error rate of a link carrying a 9-stage pseudo-random sequence. Each received bit arrives with a valid strobe. A local reference shift register, built on the same polynomial as the transmitter, seeds itself from live received bits. It then free-runs in step with the stream and compares every incoming bit with its own prediction.

Once the reference has predicted enough bits in a row, the block reports lock and begins counting received bits and mismatched bits. Mismatches while locked drop the lock flag, but counting goes on. A long enough run of consecutive mismatches raises a loss-of-sync flag and sends the block back to seeding. It retries on its own until it regains lock. Software reads the two saturating counters and may clear them at any time.

Top module: `prbs9_sync_checker`

## Requirements
- R1: The reference is a Fibonacci register of the polynomial x^9 + x^5 + 1. With state s[8:0], where s[0] holds the newest bit, the predicted bit is s[8] ^ s[4], and that bit is shifted in at s[0]. The resulting sequence obeys b[n] = b[n-9] ^ b[n-5].
- R2: In the seeding phase, each valid bit is shifted into the reference. After 9 such bits the reference holds the seed and the block begins comparing.
- R3: lock_o rises after the LOCK_RUN-th consecutive matching bit (default 16), counted from the start of comparison, and not before.
- R4: bit_cnt_o and err_cnt_o (CNT_W bits, default 32) change only on valid bits received while the block is locked, or after it has dropped lock without yet losing sync. Each increments by one per such bit (err_cnt_o only on a mismatch) and saturates at all ones.
- R5: A seed of all zeros is discarded, and 9 fresh bits are collected before comparison starts.
- R6: A mismatch while locked drops lock_o on the next cycle, and that bit is still counted as a bit and as an error. LOCK_RUN consecutive matches restore lock_o.
- R7: LOSS_RUN consecutive mismatches (default 8) after lock raise lost_o and restart seeding. A single match inside a run restarts the run.
- R8: During comparison before lock, any mismatch restarts seeding. lost_o stays high through re-acquisition and falls when lock is declared again.
- R9: On cycles with valid_i low, no state or output changes (apart from a clear).
- R10: clr_i zeroes both counters on the next clock edge, even if a counted bit arrives in the same cycle.
- R11: After reset, lock_o and lost_o are low, both counters are zero, and the block is seeding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous counter clear |
| valid_i | input | 1 | Received bit strobe |
| rx_bit_i | input | 1 | Received data bit |
| lock_o | output | 1 | Reference locked to stream |
| lost_o | output | 1 | Sync lost, re-acquiring |
| bit_cnt_o | output | CNT_W | Counted bits, saturating |
| err_cnt_o | output | CNT_W | Counted mismatches, saturating |

## Verification
The mismatch that completes the loss run is also a counted error. So in one cycle the error counter increments, lost_o rises and the reference falls back to seeding. The bench provokes this by inverting exactly LOSS_RUN transmitted bits after relock. It expects both counters to include that final bit and to stay frozen through the 9 seed bits and the comparison bits that follow. A second collision, clear against a counted bit, is driven in one cycle and must leave both counters at zero.

// File: rtl/prbs9_pkg.sv
package prbs9_pkg;
  localparam int unsigned PN_LEN = 9;
  localparam int unsigned PN_TAP = 5;

  typedef enum logic [1:0] {
    ST_SEED = 2'd0,
    ST_ACQ  = 2'd1,
    ST_LOCK = 2'd2,
    ST_HOLD = 2'd3
  } sync_st_e;
endpackage

// File: rtl/pn_ref_reg.sv
module pn_ref_reg #(
  parameter int unsigned LEN = 9,
  parameter int unsigned TAP = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           seed_i,
  input  logic           din_i,
  output logic [LEN-1:0] state_o,
  output logic           pred_o
);
  logic [LEN-1:0] sr_q;

  assign pred_o  = sr_q[LEN-1] ^ sr_q[TAP-1];
  assign state_o = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_q <= '0;
    else if (en_i) sr_q <= {sr_q[LEN-2:0], seed_i ? din_i : pred_o};
  end
endmodule

// File: rtl/run_cnt.sv
module run_cnt #(
  parameter int unsigned LIMIT = 16,
  localparam int unsigned CW   = (LIMIT < 2) ? 1 : $clog2(LIMIT)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  input  logic inc_i,
  output logic hit_o
);
  logic [CW-1:0] cnt_q;

  assign hit_o = en_i && inc_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (restart_i || hit_o)           cnt_q <= '0;
    else if (en_i)                         cnt_q <= inc_i ? cnt_q + 1'b1 : '0;
  end
endmodule

// File: rtl/sat_cnt.sv
module sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 q_o <= '0;
    else if (clr_i)              q_o <= '0;
    else if (inc_i && ~&q_o)     q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/prbs9_sync_checker.sv
module prbs9_sync_checker
  import prbs9_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned LOCK_RUN = 16,
  parameter int unsigned LOSS_RUN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             valid_i,
  input  logic             rx_bit_i,
  output logic             lock_o,
  output logic             lost_o,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  localparam int unsigned NCNT = 2;

  sync_st_e          st_q, st_d;
  logic              lost_q;
  logic [PN_LEN-1:0] ref_state;
  logic              pred_bit, mism;
  logic              in_seed, in_acq, in_count, in_track;
  logic              seed_done, match_hit, miss_hit;
  logic              seed_zero;
  logic [NCNT-1:0]   cnt_inc;
  logic [CNT_W-1:0]  cnt_q [NCNT];

  assign in_seed  = (st_q == ST_SEED);
  assign in_acq   = (st_q == ST_ACQ);
  assign in_count = (st_q == ST_LOCK) || (st_q == ST_HOLD);
  assign in_track = (st_q == ST_ACQ)  || (st_q == ST_HOLD);
  assign mism     = rx_bit_i ^ pred_bit;
  assign seed_zero = ~|{ref_state[PN_LEN-2:0], rx_bit_i};

  pn_ref_reg #(.LEN(PN_LEN), .TAP(PN_TAP)) u_ref (
    .clk_i, .rst_ni,
    .en_i    (valid_i),
    .seed_i  (in_seed),
    .din_i   (rx_bit_i),
    .state_o (ref_state),
    .pred_o  (pred_bit)
  );

  run_cnt #(.LIMIT(PN_LEN)) u_seed_run (
    .clk_i, .rst_ni,
    .en_i      (valid_i && in_seed),
    .restart_i (valid_i && !in_seed),
    .inc_i     (1'b1),
    .hit_o     (seed_done)
  );

  run_cnt #(.LIMIT(LOCK_RUN)) u_match_run (
    .clk_i, .rst_ni,
    .en_i      (valid_i && in_track),
    .restart_i (valid_i && !in_track),
    .inc_i     (!mism),
    .hit_o     (match_hit)
  );

  run_cnt #(.LIMIT(LOSS_RUN)) u_miss_run (
    .clk_i, .rst_ni,
    .en_i      (valid_i && in_count),
    .restart_i (valid_i && !in_count),
    .inc_i     (mism),
    .hit_o     (miss_hit)
  );

  always_comb begin
    st_d = st_q;
    if (valid_i) begin
      unique case (st_q)
        ST_SEED: if (seed_done && !seed_zero) st_d = ST_ACQ;
        ST_ACQ:  if (mism) st_d = ST_SEED;
                 else if (match_hit) st_d = ST_LOCK;
        ST_LOCK: if (mism) st_d = ST_HOLD;
        ST_HOLD: if (miss_hit) st_d = ST_SEED;
                 else if (match_hit) st_d = ST_LOCK;
        default: st_d = ST_SEED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SEED;
      lost_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (valid_i && miss_hit)                  lost_q <= 1'b1;
      else if (st_d == ST_LOCK && in_track)     lost_q <= 1'b0;
    end
  end

  // index 0: all counted bits, index 1: mismatched bits
  assign cnt_inc[0] = valid_i && in_count;
  assign cnt_inc[1] = valid_i && in_count && mism;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni,
      .clr_i (clr_i),
      .inc_i (cnt_inc[g]),
      .q_o   (cnt_q[g])
    );
  end

  assign bit_cnt_o = cnt_q[0];
  assign err_cnt_o = cnt_q[1];
  assign lock_o    = (st_q == ST_LOCK);
  assign lost_o    = lost_q;

  logic unused_acq;
  assign unused_acq = in_acq;
endmodule

// File: rtl/prbs9_sync_checker_sva.sv
module prbs9_sync_checker_sva #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             valid_i,
  input logic             rx_bit_i,
  input logic             lock_o,
  input logic             lost_o,
  input logic [CNT_W-1:0] bit_cnt_o,
  input logic [CNT_W-1:0] err_cnt_o
);
  // R9
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> ($stable(lock_o) && $stable(lost_o) &&
                             $stable(bit_cnt_o) && $stable(err_cnt_o)));

  // R10
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (bit_cnt_o == '0 && err_cnt_o == '0));

  // R4
  a_r4_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (bit_cnt_o == $past(bit_cnt_o) ||
                bit_cnt_o == $past(bit_cnt_o) + 1'b1));

  a_r4_frozen_when_lost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_o && !clr_i) |=> ($stable(bit_cnt_o) && $stable(err_cnt_o)));

  // R8
  a_r8_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lock_o && lost_o));

  // R7
  a_r7_lost_needs_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lost_o) |-> ($past(valid_i) && $past(rx_bit_i) == $past(rx_bit_i)));

  // R3
  a_r3_lock_needs_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(valid_i));
endmodule

bind prbs9_sync_checker prbs9_sync_checker_sva #(.CNT_W(CNT_W)) u_sva (.*);

// File: tb/tb_prbs9_sync_checker.sv
`timescale 1ns/1ps
module tb_prbs9_sync_checker;
  localparam int CW = 8;
  localparam int NSEG = 20;
  localparam logic [3:0] K_ZERO = 4'd0, K_CLEAN = 4'd1, K_INV = 4'd2, K_IDLE = 4'd3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clr_i = 1'b0, valid_i = 1'b0, rx_bit_i = 1'b0;
  logic lock_o, lost_o;
  logic [CW-1:0] bit_cnt_o, err_cnt_o;
  logic [8:0] tx = 9'h1FF;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prbs9_sync_checker #(.CNT_W(CW), .LOCK_RUN(16), .LOSS_RUN(8)) dut (
    .clk_i(clk), .rst_ni, .clr_i, .valid_i, .rx_bit_i,
    .lock_o, .lost_o, .bit_cnt_o, .err_cnt_o
  );

  function automatic logic [47:0] mk(logic [3:0] k, int n, int lk, int ls, int tot, int er);
    return {k, 12'(n), 4'(lk), 4'(ls), 12'(tot), 12'(er)};
  endfunction

  // kind, bits, lock, lost, bit count, error count after the segment
  localparam logic [47:0] SEG [NSEG] = '{
    mk(K_ZERO,   9, 0, 0,   0,  0),
    mk(K_CLEAN,  9, 0, 0,   0,  0),
    mk(K_CLEAN, 15, 0, 0,   0,  0),
    mk(K_CLEAN,  1, 1, 0,   0,  0),
    mk(K_CLEAN, 20, 1, 0,  20,  0),
    mk(K_IDLE,   5, 1, 0,  20,  0),
    mk(K_INV,    1, 0, 0,  21,  1),
    mk(K_CLEAN, 15, 0, 0,  36,  1),
    mk(K_CLEAN,  1, 1, 0,  37,  1),
    mk(K_INV,    7, 0, 0,  44,  8),
    mk(K_CLEAN,  1, 0, 0,  45,  8),
    mk(K_INV,    7, 0, 0,  52, 15),
    mk(K_INV,    1, 0, 1,  53, 16),
    mk(K_CLEAN,  9, 0, 1,  53, 16),
    mk(K_CLEAN,  5, 0, 1,  53, 16),
    mk(K_INV,    1, 0, 1,  53, 16),
    mk(K_CLEAN,  9, 0, 1,  53, 16),
    mk(K_CLEAN, 15, 0, 1,  53, 16),
    mk(K_CLEAN,  1, 1, 0,  53, 16),
    mk(K_CLEAN,250, 1, 0, 255, 16)
  };
  localparam string TAG [NSEG] = '{
    "R5", "R2", "R3", "R3", "R1", "R9", "R6", "R6", "R6", "R7",
    "R7", "R7", "R7", "R8", "R8", "R8", "R8", "R8", "R8", "R4"
  };

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag, int lk, int ls, int tot, int er);
    chk(tag, "lock_o", int'(lock_o), lk);
    chk(tag, "lost_o", int'(lost_o), ls);
    chk(tag, "bit_cnt_o", int'(bit_cnt_o), tot);
    chk(tag, "err_cnt_o", int'(err_cnt_o), er);
  endtask

  task automatic drive(logic v, logic b, logic c);
    @(negedge clk);
    valid_i = v; rx_bit_i = b; clr_i = c;
  endtask

  task automatic settle();
    @(negedge clk);
    valid_i = 1'b0; clr_i = 1'b0;
  endtask

  function automatic logic tx_step();
    logic b;
    b = tx[8] ^ tx[4];
    tx = {tx[7:0], b};
    return b;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R11", 0, 0, 0, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int s = 0; s < NSEG; s++) begin
      logic [3:0] k;
      int n;
      k = SEG[s][47:44];
      n = int'(SEG[s][43:32]);
      for (int i = 0; i < n; i++) begin
        case (k)
          K_ZERO:  drive(1'b1, 1'b0, 1'b0);
          K_CLEAN: drive(1'b1, tx_step(), 1'b0);
          K_INV:   drive(1'b1, ~tx_step(), 1'b0);
          default: drive(1'b0, i[0], 1'b0);
        endcase
      end
      settle();
      chk_all(TAG[s], int'(SEG[s][31:28]), int'(SEG[s][27:24]),
              int'(SEG[s][23:12]), int'(SEG[s][11:0]));
    end

    // R10: clear alone, then clear colliding with a counted bit
    drive(1'b0, 1'b0, 1'b1);
    settle();
    chk_all("R10", 1, 0, 0, 0);
    drive(1'b1, ~tx_step(), 1'b1);
    settle();
    chk("R10", "bit_cnt_o clear wins", int'(bit_cnt_o), 0);
    chk("R10", "err_cnt_o clear wins", int'(err_cnt_o), 0);
    chk("R6", "lock_o after collided mismatch", int'(lock_o), 0);
    for (int i = 0; i < 3; i++) drive(1'b1, tx_step(), 1'b0);
    settle();
    chk("R4", "bit_cnt_o after clear", int'(bit_cnt_o), 3);
    chk("R4", "err_cnt_o after clear", int'(err_cnt_o), 0);

    // R11: reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk_all("R11", 0, 0, 0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule